// File: doc/BRIEF.md
# Generalized Parallel Counter Library

This block is a set of purely combinational counters for compressing columns of bits inside a multi-operand adder. Each counter takes bits from one column of a dot matrix, or from two adjacent columns. It returns the weighted count of its set inputs as a short binary word. Inputs from the lower column count one and inputs from the higher column count two.

A shape is described by two parameters: `K1`, the number of weight-two inputs, and `K0`, the number of weight-one inputs. The top module picks its internal structure from these parameters. Five shapes are supported:

| K1 | K0 | Output bits |
|----|----|-------------|
| 0  | 6  | 3 |
| 0  | 5  | 3 |
| 3  | 3  | 4 |
| 3  | 4  | 4 |
| 3  | 5  | 4 |

Every shape has the same internal structure. Full and half adders first reduce the inputs to at most two bits per column. A short ripple-carry stage then adds those two rows, so the final addition sits on a carry path. The ripple stage takes no carry in: its lowest carry is tied to zero, so counters placed side by side stay independent.

Top module: `gpc_counter`

## Requirements
- R1: For every input pattern, `cnt_o` equals the number of set bits in `w0_i` plus twice the number of set bits in `w1_i`.
- R2: The width of `cnt_o` is ceil(log2(2*K1+K0+1)). This is 3 bits for the shapes (0,6) and (0,5), and 4 bits for the shapes (3,3), (3,4) and (3,5).
- R3: With every input set, `cnt_o` equals 2*K1+K0. The values are 6, 5, 9, 10 and 11 for the five shapes.
- R4: With every input clear, `cnt_o` is zero.
- R5: When K1 is 0, `w1_i` is one bit wide and has no effect on `cnt_o`.
- R6: Any single set bit of `w0_i` alone gives 1, and any single set bit of `w1_i` alone gives 2.
- R7: The ripple stage `gpc_ripple` adds two W-bit rows with a carry in of zero. Its W+1-bit result equals their arithmetic sum.
- R8: `cnt_o` never exceeds 2*K1+K0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| w0_i | input | K0 | Bits of weight one (lower column) |
| w1_i | input | max(K1,1) | Bits of weight two (upper column); ignored when K1 is 0 |
| cnt_o | output | ceil(log2(2*K1+K0+1)) | Weighted count of set inputs |

## Verification
The five shapes are instantiated side by side and driven from one 8-bit pattern. Each shape takes a slice of that pattern, so sweeping all 256 values walks every input combination of every shape. This sweep tells apart the cases where a reduction adder is misconnected, a carry lands in the wrong column, or the weight of an input is wrong.

For the two single-column shapes, the top bit of the pattern drives only `w1_i`. Each of their combinations is therefore seen with that bit both clear and set, which shows whether `w1_i` leaks into the result.

Directed all-zero, all-one and one-hot patterns isolate the zero case, the maximum value and the weight of each input. A batch of seeded random patterns repeats the comparison. The ripple stage is also swept exhaustively on its own, so that a fault in the carry path can be separated from a fault in the reduction.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  function automatic int unsigned gpc_max_val(int unsigned k1, int unsigned k0);
    return 2 * k1 + k0;
  endfunction

  function automatic int unsigned gpc_out_bits(int unsigned k1, int unsigned k0);
    return $clog2(2 * k1 + k0 + 1);
  endfunction

  function automatic bit gpc_supported(int unsigned k1, int unsigned k0);
    return (k1 == 0 && (k0 == 6 || k0 == 5)) ||
           (k1 == 3 && (k0 == 3 || k0 == 4 || k0 == 5));
  endfunction

endpackage

// File: rtl/gpc_fa.sv
module gpc_fa (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i ^ c_i;
  assign co_o = (a_i & b_i) | (c_i & (a_i ^ b_i));

  always_comb begin
    assert_fa_sum_R1: assert ({co_o, s_o} == 2'(a_i) + 2'(b_i) + 2'(c_i))
      else $error("full adder result wrong");
  end
endmodule

// File: rtl/gpc_ha.sv
module gpc_ha (
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic co_o
);
  assign s_o  = a_i ^ b_i;
  assign co_o = a_i & b_i;

  always_comb begin
    assert_ha_sum_R1: assert ({co_o, s_o} == 2'(a_i) + 2'(b_i))
      else $error("half adder result wrong");
  end
endmodule

// File: rtl/gpc_ripple.sv
// Two-row ripple stage; carry in tied low so neighbours stay independent.
module gpc_ripple #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W:0]   sum_o
);
  logic [W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_bit
    gpc_fa u_fa (
      .a_i (x_i[i]),
      .b_i (y_i[i]),
      .c_i (carry[i]),
      .s_o (sum_o[i]),
      .co_o(carry[i+1])
    );
  end

  assign sum_o[W] = carry[W];

  always_comb begin
    assert_ripple_sum_R7: assert (sum_o == (W+1)'(x_i) + (W+1)'(y_i))
      else $error("ripple stage result wrong");
  end
endmodule

// File: rtl/gpc_counter.sv
module gpc_counter
  import gpc_pkg::*;
#(
  parameter int unsigned K1 = 3,
  parameter int unsigned K0 = 5,
  localparam int unsigned W1B  = (K1 == 0) ? 1 : K1,
  localparam int unsigned NOUT = gpc_out_bits(K1, K0)
) (
  input  logic [K0-1:0]   w0_i,
  input  logic [W1B-1:0]  w1_i,
  output logic [NOUT-1:0] cnt_o
);
  localparam int unsigned MAXV = gpc_max_val(K1, K0);
  localparam int unsigned RW   = NOUT - 1;

  logic [RW-1:0] row_x, row_y;
  logic [NOUT-1:0] rsum;

  if (K1 == 0 && K0 == 6) begin : g_s06
    logic s0, c0, s1, c1;
    gpc_fa u_fa0 (.a_i(w0_i[0]), .b_i(w0_i[1]), .c_i(w0_i[2]), .s_o(s0), .co_o(c0));
    gpc_fa u_fa1 (.a_i(w0_i[3]), .b_i(w0_i[4]), .c_i(w0_i[5]), .s_o(s1), .co_o(c1));
    assign row_x = RW'({c0, s0});
    assign row_y = RW'({c1, s1});
  end else if (K1 == 0 && K0 == 5) begin : g_s05
    logic s0, c0, s1, c1;
    gpc_fa u_fa0 (.a_i(w0_i[0]), .b_i(w0_i[1]), .c_i(w0_i[2]), .s_o(s0), .co_o(c0));
    gpc_ha u_ha0 (.a_i(w0_i[3]), .b_i(w0_i[4]), .s_o(s1), .co_o(c1));
    assign row_x = RW'({c0, s0});
    assign row_y = RW'({c1, s1});
  end else if (K1 == 3 && K0 == 3) begin : g_s33
    logic s0, c0, s1, c1;
    gpc_fa u_fa0 (.a_i(w0_i[0]), .b_i(w0_i[1]), .c_i(w0_i[2]), .s_o(s0), .co_o(c0));
    gpc_fa u_fa1 (.a_i(w1_i[0]), .b_i(w1_i[1]), .c_i(w1_i[2]), .s_o(s1), .co_o(c1));
    assign row_x = RW'({c1, c0, s0});
    assign row_y = RW'({1'b0, s1, 1'b0});
  end else if (K1 == 3 && K0 == 4) begin : g_s34
    logic s0, c0, s1, c1;
    gpc_fa u_fa0 (.a_i(w0_i[0]), .b_i(w0_i[1]), .c_i(w0_i[2]), .s_o(s0), .co_o(c0));
    gpc_fa u_fa1 (.a_i(w1_i[0]), .b_i(w1_i[1]), .c_i(w1_i[2]), .s_o(s1), .co_o(c1));
    assign row_x = RW'({c1, c0, s0});
    assign row_y = RW'({1'b0, s1, w0_i[3]});
  end else if (K1 == 3 && K0 == 5) begin : g_s35
    logic s0, c0, s1, c1, s2, c2, t1, u2;
    gpc_fa u_fa0 (.a_i(w0_i[0]), .b_i(w0_i[1]), .c_i(w0_i[2]), .s_o(s0), .co_o(c0));
    gpc_ha u_ha0 (.a_i(w0_i[3]), .b_i(w0_i[4]), .s_o(s2), .co_o(c2));
    gpc_fa u_fa1 (.a_i(w1_i[0]), .b_i(w1_i[1]), .c_i(w1_i[2]), .s_o(s1), .co_o(c1));
    // column 1 holds three bits; reduce once more before the ripple
    gpc_fa u_fa2 (.a_i(c0), .b_i(c2), .c_i(s1), .s_o(t1), .co_o(u2));
    assign row_x = RW'({c1, t1, s0});
    assign row_y = RW'({u2, 1'b0, s2});
  end else begin : g_none
    assign row_x = '0;
    assign row_y = '0;
  end

  gpc_ripple #(.W(RW)) u_rip (
    .x_i  (row_x),
    .y_i  (row_y),
    .sum_o(rsum)
  );

  assign cnt_o = rsum;

  initial begin
    assert_shape_ok_R2: assert (gpc_supported(K1, K0))
      else $error("unsupported counter shape");
  end

  always_comb begin
    assert_weighted_sum_R1: assert (32'(cnt_o) ==
        32'($countones(w0_i)) + ((K1 == 0) ? 32'd0 : 32'd2 * 32'($countones(w1_i))))
      else $error("weighted count wrong");
    assert_no_overflow_R8: assert (32'(cnt_o) <= MAXV)
      else $error("count above shape maximum");
  end
endmodule

// File: tb/sim_gpc_counter.sv
module sim_gpc_counter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] pat;
  logic [2:0] rx, ry;

  logic [3:0] o35, o34, o33;
  logic [2:0] o06, o05;
  logic [3:0] orip;

  gpc_counter #(.K1(3), .K0(5)) u0   (.w0_i(pat[4:0]), .w1_i(pat[7:5]), .cnt_o(o35));
  gpc_counter #(.K1(3), .K0(4)) u_34 (.w0_i(pat[3:0]), .w1_i(pat[6:4]), .cnt_o(o34));
  gpc_counter #(.K1(3), .K0(3)) u_33 (.w0_i(pat[2:0]), .w1_i(pat[5:3]), .cnt_o(o33));
  gpc_counter #(.K1(0), .K0(6)) u_06 (.w0_i(pat[5:0]), .w1_i(pat[7]),   .cnt_o(o06));
  gpc_counter #(.K1(0), .K0(5)) u_05 (.w0_i(pat[4:0]), .w1_i(pat[7]),   .cnt_o(o05));
  gpc_ripple  #(.W(3))          u_rp (.x_i(rx), .y_i(ry), .sum_o(orip));

  function automatic int ones(int v, int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += (v >> i) & 1;
    return c;
  endfunction

  function automatic int ref_cnt(int k1, int k0, int w0, int w1);
    return ones(w0, k0) + 2 * ones(w1, k1);
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (pat=%02h)", req, act, exp, pat);
    end
  endtask

  task automatic check_all(string req);
    int p = int'(pat);
    check(req, int'(o35), ref_cnt(3, 5, p & 31, (p >> 5) & 7));
    check(req, int'(o34), ref_cnt(3, 4, p & 15, (p >> 4) & 7));
    check(req, int'(o33), ref_cnt(3, 3, p & 7, (p >> 3) & 7));
    check(req, int'(o06), ref_cnt(0, 6, p & 63, 0));
    check(req, int'(o05), ref_cnt(0, 5, p & 31, 0));
  endtask

  task automatic apply(logic [7:0] v);
    @(negedge clk);
    pat = v;
    #1;
  endtask

  initial begin
    int seed_dummy;
    pat = '0; rx = '0; ry = '0;
    seed_dummy = int'($urandom(32'd1234));
    // R2: output widths
    n_chk++; if ($bits(o35) != 4 || $bits(u0.cnt_o) != 4) begin n_bad++; $display("FAIL R2: actual %0d expected 4", $bits(u0.cnt_o)); end
    n_chk++; if ($bits(u_06.cnt_o) != 3) begin n_bad++; $display("FAIL R2: actual %0d expected 3", $bits(u_06.cnt_o)); end
    n_chk++; if ($bits(u_33.cnt_o) != 4) begin n_bad++; $display("FAIL R2: actual %0d expected 4", $bits(u_33.cnt_o)); end
    // R4: all clear
    apply(8'h00);
    check("R4", int'(o35), 0); check("R4", int'(o34), 0); check("R4", int'(o33), 0);
    check("R4", int'(o06), 0); check("R4", int'(o05), 0);
    // R3 / R8: all set
    apply(8'hFF);
    check("R3", int'(o35), 11); check("R3", int'(o34), 10); check("R3", int'(o33), 9);
    check("R3", int'(o06), 6);  check("R3", int'(o05), 5);
    // R6: one-hot weights
    for (int i = 0; i < 5; i++) begin apply(8'(1 << i)); check("R6 w0", int'(o35), 1); end
    for (int i = 5; i < 8; i++) begin apply(8'(1 << i)); check("R6 w1", int'(o35), 2); end
    // R5: w1 ignored on single-column shapes
    apply(8'h80); check("R5", int'(o06), 0); check("R5", int'(o05), 0);
    apply(8'hBF); check("R5", int'(o06), 6);
    apply(8'h3F); check("R5", int'(o06), 6);
    // R1 / R8: exhaustive sweep
    for (int p = 0; p < 256; p++) begin
      apply(8'(p));
      check_all("R1");
      n_chk++;
      if (int'(o35) > 11 || int'(o06) > 6) begin
        n_bad++; $display("FAIL R8: actual %0d/%0d expected <=11/<=6", o35, o06);
      end
    end
    // R1: seeded random patterns
    for (int k = 0; k < 200; k++) begin
      apply(8'($urandom));
      check_all("R1 rnd");
    end
    // R7: ripple stage exhaustive
    for (int a = 0; a < 8; a++) begin
      for (int b = 0; b < 8; b++) begin
        @(negedge clk);
        rx = 3'(a); ry = 3'(b);
        #1;
        check("R7", int'(orip), a + b);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule